// File: doc/BRIEF.md
# Posted-Write Buffer Bridge

This bridge sits on a simplified single-beat write path between a write master and a write slave. Every accepted write is stored whole (ID, address, data and the 4-bit cache attribute) in a small in-order queue and then sent downstream one at a time. For a write that may be held back, the bridge answers the master itself with an OKAY carrying the write's ID. The slave's later answer for that write is absorbed, and an error in it raises a sticky flag.

For a write that must not be held back, no local answer is given. The master waits for the slave's own response code, which is returned under the write's original ID. Because the queue keeps acceptance order, every earlier held write, whatever its ID, has reached the slave and been answered before the strict write goes out. The bridge accepts nothing new until that strict write has been answered. An attribute whose allocate hints are set without the cacheable bit is reserved: the bridge flags it and handles the write as strict.

All three data-carrying interfaces follow valid/ready rules. A transfer happens on a rising edge where both valid and ready are high. Once valid is raised, it and its payload stay unchanged until that transfer happens. Back-pressure comes from three sources. `up_ready` falls while the queue is full, while a strict write is pending, or while an unaccepted response occupies the response slot. `dn_rsp_ready` holds back a strict write's slave answer while the master's response slot is busy.

Top module: `wbuf_bridge`

## Requirements
- R1: Cache attribute bit 0 marks the write bufferable, bit 1 cacheable, bit 2 read-allocate, bit 3 write-allocate. A write with bit 2 or bit 3 high and bit 1 low is reserved. `attr_err` is high for exactly the one cycle after such a write is accepted, and low after any other acceptance. A reserved write is handled as non-bufferable.
- R2: A bufferable (non-reserved) write gets a master response with code 2'b00 (OKAY) and its own ID. The response is valid in the cycle right after acceptance.
- R3: A non-bufferable write gets no local response. The master receives the slave's 2-bit code (00 OKAY, 01 EXOKAY, 10 SLVERR, 11 DECERR) together with the write's original ID.
- R4: Writes leave downstream in acceptance order with unchanged ID, address and data.
- R5: After a non-bufferable write is accepted, `up_ready` stays low until that write's response is forwarded. Every earlier held write, including those with the same ID, goes downstream first.
- R6: The queue holds at most DEPTH (default 4) writes. `up_ready` is low while it is full.
- R7: Slave responses for bufferable writes are consumed and never forwarded. A code with bit 1 set (SLVERR or DECERR) sets `sticky_err`, which stays high until reset.
- R8: At most one write is outstanding downstream. `dn_valid` stays low from a downstream transfer until its response transfer.
- R9: A synchronous active-low reset empties the queue and clears pending state. After reset, `up_ready` is high and `dn_valid`, `up_rsp_valid`, `attr_err` and `sticky_err` are low. Writes held before the reset never appear downstream.
- R10: While `up_rsp_valid` is high and `up_rsp_ready` is low, the response and its ID stay unchanged. While `dn_valid` is high and `dn_ready` is low, the downstream payload stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_valid | input | 1 | Master write request valid |
| up_ready | output | 1 | Bridge can accept a write |
| up_id | input | IW | Write transaction ID |
| up_addr | input | AW | Write address |
| up_data | input | DW | Write data (single beat) |
| up_cache | input | 4 | Cache attribute |
| up_rsp_valid | output | 1 | Response to master valid |
| up_rsp_ready | input | 1 | Master takes the response |
| up_rsp_id | output | IW | Response ID |
| up_rsp_code | output | 2 | Response code |
| dn_valid | output | 1 | Downstream write valid |
| dn_ready | input | 1 | Slave accepts the write |
| dn_id | output | IW | Downstream ID |
| dn_addr | output | AW | Downstream address |
| dn_data | output | DW | Downstream data |
| dn_cache | output | 4 | Downstream cache attribute |
| dn_rsp_valid | input | 1 | Slave response valid |
| dn_rsp_ready | output | 1 | Bridge takes the slave response |
| dn_rsp_code | input | 2 | Slave response code |
| attr_err | output | 1 | One-cycle flag for a reserved attribute |
| sticky_err | output | 1 | Error seen on an absorbed response |

## Verification
A write is accepted on the edge where `up_valid` and `up_ready` are both high. The local OKAY for a bufferable write is registered on that same edge, so it transfers on the next edge when the master is ready, and the scoreboard compares that edge number exactly. `attr_err` is read in the cycle after acceptance, and `up_ready` is checked low in that same cycle for strict writes. The responses of strict writes and the downstream order depend on slave latency, so they are checked by sequence, not by cycle. All sampling happens a few nanoseconds after the falling edge, once the combinational ready paths have settled.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  localparam int CACHE_W    = 4;
  localparam int BIT_BUF    = 0;
  localparam int BIT_CACHE  = 1;
  localparam int BIT_RALLOC = 2;
  localparam int BIT_WALLOC = 3;

  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01,
    RESP_SLVERR = 2'b10,
    RESP_DECERR = 2'b11
  } resp_e;
endpackage

// File: rtl/wbuf_attr.sv
module wbuf_attr
  import wbuf_pkg::*;
(
  input  logic [CACHE_W-1:0] cache,
  output logic               reserved,
  output logic               posted
);
  // allocate hints without the cacheable bit form a reserved code
  assign reserved = (cache[BIT_RALLOC] | cache[BIT_WALLOC]) & ~cache[BIT_CACHE];
  assign posted   = cache[BIT_BUF] & ~reserved;
endmodule

// File: rtl/wbuf_fifo.sv
module wbuf_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
endmodule

// File: rtl/wbuf_issue.sv
module wbuf_issue #(
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          head_valid,
  input  logic          head_posted,
  input  logic [IW-1:0] head_id,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic          pop,
  input  logic          dn_rsp_valid,
  input  logic [1:0]    dn_rsp_code,
  output logic          dn_rsp_ready,
  input  logic          slot_free,
  output logic          fwd_valid,
  output logic [IW-1:0] fwd_id,
  output logic [1:0]    fwd_code,
  output logic          sticky_err
);
  logic          inflight;
  logic          infl_posted;
  logic [IW-1:0] infl_id;
  logic          rsp_fire;

  assign dn_valid     = head_valid & ~inflight;
  assign pop          = dn_valid & dn_ready;
  // a strict write's answer waits until the master slot can take it
  assign dn_rsp_ready = inflight & (infl_posted | slot_free);
  assign rsp_fire     = dn_rsp_valid & dn_rsp_ready;
  assign fwd_valid    = rsp_fire & ~infl_posted;
  assign fwd_id       = infl_id;
  assign fwd_code     = dn_rsp_code;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inflight    <= 1'b0;
      infl_posted <= 1'b0;
      infl_id     <= '0;
      sticky_err  <= 1'b0;
    end else begin
      if (pop) begin
        inflight    <= 1'b1;
        infl_posted <= head_posted;
        infl_id     <= head_id;
      end else if (rsp_fire) begin
        inflight    <= 1'b0;
      end
      if (rsp_fire && infl_posted && dn_rsp_code[1])
        sticky_err <= 1'b1;
    end
  end
endmodule

// File: rtl/wbuf_rsp_slot.sv
module wbuf_rsp_slot
  import wbuf_pkg::*;
#(
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          early_load,
  input  logic [IW-1:0] early_id,
  input  logic          fwd_load,
  input  logic [IW-1:0] fwd_id,
  input  logic [1:0]    fwd_code,
  input  logic          up_rsp_ready,
  output logic          up_rsp_valid,
  output logic [IW-1:0] up_rsp_id,
  output logic [1:0]    up_rsp_code,
  output logic          slot_free
);
  assign slot_free = ~up_rsp_valid | up_rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_rsp_valid <= 1'b0;
      up_rsp_id    <= '0;
      up_rsp_code  <= RESP_OKAY;
    end else if (early_load) begin
      up_rsp_valid <= 1'b1;
      up_rsp_id    <= early_id;
      up_rsp_code  <= RESP_OKAY;
    end else if (fwd_load) begin
      up_rsp_valid <= 1'b1;
      up_rsp_id    <= fwd_id;
      up_rsp_code  <= fwd_code;
    end else if (up_rsp_ready) begin
      up_rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/wbuf_bridge.sv
module wbuf_bridge
  import wbuf_pkg::*;
#(
  parameter int IW    = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               up_valid,
  output logic               up_ready,
  input  logic [IW-1:0]      up_id,
  input  logic [AW-1:0]      up_addr,
  input  logic [DW-1:0]      up_data,
  input  logic [CACHE_W-1:0] up_cache,
  output logic               up_rsp_valid,
  input  logic               up_rsp_ready,
  output logic [IW-1:0]      up_rsp_id,
  output logic [1:0]         up_rsp_code,
  output logic               dn_valid,
  input  logic               dn_ready,
  output logic [IW-1:0]      dn_id,
  output logic [AW-1:0]      dn_addr,
  output logic [DW-1:0]      dn_data,
  output logic [CACHE_W-1:0] dn_cache,
  input  logic               dn_rsp_valid,
  output logic               dn_rsp_ready,
  input  logic [1:0]         dn_rsp_code,
  output logic               attr_err,
  output logic               sticky_err
);
  localparam int EW = 1 + IW + AW + DW + CACHE_W;

  logic          reserved, posted, accept;
  logic          fifo_empty, fifo_full, fifo_pop;
  logic [EW-1:0] entry_in, entry_out;
  logic          head_posted;
  logic          slot_free, fwd_valid;
  logic [IW-1:0] fwd_id;
  logic [1:0]    fwd_code;
  logic          nb_wait;

  wbuf_attr u_attr (
    .cache    (up_cache),
    .reserved (reserved),
    .posted   (posted)
  );

  assign up_ready = ~fifo_full & ~nb_wait & slot_free;
  assign accept   = up_valid & up_ready;
  assign entry_in = {posted, up_id, up_addr, up_data, up_cache};

  wbuf_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (accept),
    .din   (entry_in),
    .pop   (fifo_pop),
    .dout  (entry_out),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  assign {head_posted, dn_id, dn_addr, dn_data, dn_cache} = entry_out;

  wbuf_issue #(.IW(IW)) u_issue (
    .clk          (clk),
    .rst_n        (rst_n),
    .head_valid   (~fifo_empty),
    .head_posted  (head_posted),
    .head_id      (dn_id),
    .dn_valid     (dn_valid),
    .dn_ready     (dn_ready),
    .pop          (fifo_pop),
    .dn_rsp_valid (dn_rsp_valid),
    .dn_rsp_code  (dn_rsp_code),
    .dn_rsp_ready (dn_rsp_ready),
    .slot_free    (slot_free),
    .fwd_valid    (fwd_valid),
    .fwd_id       (fwd_id),
    .fwd_code     (fwd_code),
    .sticky_err   (sticky_err)
  );

  wbuf_rsp_slot #(.IW(IW)) u_slot (
    .clk          (clk),
    .rst_n        (rst_n),
    .early_load   (accept & posted),
    .early_id     (up_id),
    .fwd_load     (fwd_valid),
    .fwd_id       (fwd_id),
    .fwd_code     (fwd_code),
    .up_rsp_ready (up_rsp_ready),
    .up_rsp_valid (up_rsp_valid),
    .up_rsp_id    (up_rsp_id),
    .up_rsp_code  (up_rsp_code),
    .slot_free    (slot_free)
  );

  // strict write pending: intake closed until its real answer is handed up
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nb_wait  <= 1'b0;
      attr_err <= 1'b0;
    end else begin
      if (accept && !posted) nb_wait <= 1'b1;
      else if (fwd_valid)    nb_wait <= 1'b0;
      attr_err <= accept & reserved;
    end
  end
endmodule

// File: rtl/wbuf_bridge_chk.sv
module wbuf_bridge_chk #(
  parameter int IW    = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          up_valid,
  input logic          up_ready,
  input logic [IW-1:0] up_id,
  input logic [3:0]    up_cache,
  input logic          up_rsp_valid,
  input logic          up_rsp_ready,
  input logic [IW-1:0] up_rsp_id,
  input logic [1:0]    up_rsp_code,
  input logic          dn_valid,
  input logic          dn_ready,
  input logic [IW-1:0] dn_id,
  input logic [AW-1:0] dn_addr,
  input logic [DW-1:0] dn_data,
  input logic          dn_rsp_valid,
  input logic          dn_rsp_ready,
  input logic          attr_err,
  input logic          sticky_err
);
  localparam int OW = $clog2(DEPTH + 1) + 1;

  logic          acc, rsv, pst, dn_fire, rsp_fire;
  logic [OW-1:0] occ;
  logic          outst;

  assign acc      = up_valid & up_ready;
  assign rsv      = (up_cache[2] | up_cache[3]) & ~up_cache[1];
  assign pst      = up_cache[0] & ~rsv;
  assign dn_fire  = dn_valid & dn_ready;
  assign rsp_fire = dn_rsp_valid & dn_rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ   <= '0;
      outst <= 1'b0;
    end else begin
      occ <= occ + OW'(acc) - OW'(dn_fire);
      if (dn_fire)       outst <= 1'b1;
      else if (rsp_fire) outst <= 1'b0;
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> (occ < OW'(DEPTH)));
  p_full_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == OW'(DEPTH)) |-> !up_ready);
  p_early_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && pst) |=> (up_rsp_valid && up_rsp_code == 2'b00 && up_rsp_id == $past(up_id)));
  p_attr_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (attr_err == $past(rsv)));
  p_one_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    outst |-> !dn_valid);
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_err |=> sticky_err);
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rsp_valid && !up_rsp_ready) |=>
      (up_rsp_valid && $stable(up_rsp_id) && $stable(up_rsp_code)));
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=>
      (dn_valid && $stable(dn_id) && $stable(dn_addr) && $stable(dn_data)));
endmodule

bind wbuf_bridge wbuf_bridge_chk #(.IW(IW), .AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .up_valid     (up_valid),
  .up_ready     (up_ready),
  .up_id        (up_id),
  .up_cache     (up_cache),
  .up_rsp_valid (up_rsp_valid),
  .up_rsp_ready (up_rsp_ready),
  .up_rsp_id    (up_rsp_id),
  .up_rsp_code  (up_rsp_code),
  .dn_valid     (dn_valid),
  .dn_ready     (dn_ready),
  .dn_id        (dn_id),
  .dn_addr      (dn_addr),
  .dn_data      (dn_data),
  .dn_rsp_valid (dn_rsp_valid),
  .dn_rsp_ready (dn_rsp_ready),
  .attr_err     (attr_err),
  .sticky_err   (sticky_err)
);

// File: tb/tb_wbuf_bridge.sv
`timescale 1ns/1ps
module tb_wbuf_bridge;
  localparam int IW = 4, AW = 16, DW = 32, DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic up_valid = 1'b0, up_ready;
  logic [IW-1:0] up_id = '0;
  logic [AW-1:0] up_addr = '0;
  logic [DW-1:0] up_data = '0;
  logic [3:0] up_cache = '0;
  logic up_rsp_valid, up_rsp_ready = 1'b1;
  logic [IW-1:0] up_rsp_id;
  logic [1:0] up_rsp_code;
  logic dn_valid, dn_ready = 1'b0;
  logic [IW-1:0] dn_id;
  logic [AW-1:0] dn_addr;
  logic [DW-1:0] dn_data;
  logic [3:0] dn_cache;
  logic dn_rsp_valid = 1'b0, dn_rsp_ready;
  logic [1:0] dn_rsp_code = 2'b00;
  logic attr_err, sticky_err;

  wbuf_bridge #(.IW(IW), .AW(AW), .DW(DW), .DEPTH(DEPTH)) dut (.*);

  always #4 clk = ~clk;

  typedef struct { logic [IW-1:0] id; logic [AW-1:0] addr; logic [DW-1:0] data; } dn_item_t;
  typedef struct { logic [IW-1:0] id; logic [1:0] code; int edge_no; bit timed; } rsp_item_t;
  dn_item_t  dn_exp[$];
  rsp_item_t rsp_exp[$];

  int cyc = 0, total = 0, bad = 0, r8_viol = 0;
  bit timed = 1'b1, dn_gate = 1'b1, exp_sticky = 1'b0, done = 1'b0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_rsv(input logic [3:0] c);
    return (c[2] | c[3]) & ~c[1];
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // driver: offers one write, pushes the expected downstream item and response
  task automatic send(input logic [IW-1:0] id, input logic [AW-1:0] addr,
                      input logic [DW-1:0] data, input logic [3:0] cache);
    bit rsv, pst;
    rsv = is_rsv(cache);
    pst = cache[0] & ~rsv;
    @(negedge clk);
    up_valid = 1'b1; up_id = id; up_addr = addr; up_data = data; up_cache = cache;
    #2;
    while (!up_ready) begin @(negedge clk); #2; end
    dn_exp.push_back('{id: id, addr: addr, data: data});
    rsp_exp.push_back('{id: id, code: pst ? 2'b00 : data[31:30],
                        edge_no: cyc + 2, timed: timed & pst});
    @(negedge clk);
    up_valid = 1'b0;
    #3;
    chk(attr_err == rsv, "R1", "attr_err after accept", 64'(attr_err), 64'(rsv));
    if (!pst)
      chk(up_ready == 1'b0, "R5", "up_ready while strict write pending", 64'(up_ready), 64'd0);
  endtask

  // monitor: upstream responses against the scoreboard
  initial forever begin
    @(negedge clk); #3;
    if (rst_n && up_rsp_valid && up_rsp_ready) begin
      if (rsp_exp.size() == 0) begin
        chk(1'b0, "R7", "unexpected response", 64'(up_rsp_id), 64'd0);
      end else begin
        rsp_item_t e;
        e = rsp_exp.pop_front();
        chk(up_rsp_id == e.id, "R3", "response id", 64'(up_rsp_id), 64'(e.id));
        chk(up_rsp_code == e.code, "R2/R3 code", "response code", 64'(up_rsp_code), 64'(e.code));
        if (e.timed)
          chk(cyc + 1 == e.edge_no, "R2", "early response edge", 64'(cyc + 1), 64'(e.edge_no));
      end
    end
  end

  // slave model: order scoreboard, delayed answers coded by data[31:30]
  initial begin
    bit busy = 1'b0, fired = 1'b0, pend_pst = 1'b0;
    int dly = 0;
    logic [1:0] pend_code = 2'b00;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        busy = 1'b0; fired = 1'b0; dn_rsp_valid = 1'b0;
      end
      if (fired) begin
        if (pend_pst && pend_code[1]) exp_sticky = 1'b1;
        dn_rsp_valid = 1'b0; busy = 1'b0; fired = 1'b0;
      end
      if (busy && !dn_rsp_valid) begin
        if (dly == 0) begin dn_rsp_valid = 1'b1; dn_rsp_code = pend_code; end
        else dly--;
      end
      dn_ready = dn_gate && ((cyc % 3) != 1);
      #2;
      if (rst_n && dn_valid && busy) r8_viol++;
      if (rst_n && dn_valid && dn_ready) begin
        if (dn_exp.size() == 0) begin
          chk(1'b0, "R4", "unexpected downstream write", 64'(dn_addr), 64'd0);
        end else begin
          dn_item_t e;
          e = dn_exp.pop_front();
          chk(dn_id == e.id && dn_addr == e.addr && dn_data == e.data, "R4",
              "downstream order", {dn_addr, dn_data}, {e.addr, e.data});
        end
        busy = 1'b1;
        pend_code = dn_data[31:30];
        pend_pst = dn_cache[0] & ~is_rsv(dn_cache);
        dly = int'(dn_data[1:0]);
      end
      if (rst_n && dn_rsp_valid && dn_rsp_ready) fired = 1'b1;
    end
  end

  task automatic wait_idle();
    int n = 0;
    while ((dn_exp.size() != 0 || rsp_exp.size() != 0) && n < 400) begin
      @(negedge clk); n++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    dn_exp.delete(); rsp_exp.delete(); exp_sticky = 1'b0;
    rst_n = 1'b1;
    #3;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R8", "watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    do_reset();
    // R9: reset state
    chk(up_ready == 1'b1, "R9", "up_ready after reset", 64'(up_ready), 64'd1);
    chk(dn_valid == 1'b0, "R9", "dn_valid after reset", 64'(dn_valid), 64'd0);
    chk(up_rsp_valid == 1'b0, "R9", "up_rsp_valid after reset", 64'(up_rsp_valid), 64'd0);
    chk({attr_err, sticky_err} == 2'b00, "R9", "flags after reset", 64'({attr_err, sticky_err}), 64'd0);

    // bufferable writes with several legal encodings (R2, R4)
    send(4'h1, 16'h0010, 32'h0000_1001, 4'b0001);
    send(4'h2, 16'h0020, 32'h0000_2002, 4'b0011);
    send(4'h3, 16'h0030, 32'h0000_3003, 4'b1111);
    send(4'h1, 16'h0040, 32'h0000_4000, 4'b0111);
    send(4'h4, 16'h0050, 32'h0000_5001, 4'b1011);
    wait_idle();

    // non-bufferable writes: slave codes OKAY, SLVERR, EXOKAY, DECERR (R3, R5)
    send(4'h6, 16'h0100, 32'h0000_0102, 4'b0000);
    send(4'h7, 16'h0104, 32'h8000_0101, 4'b0010);
    send(4'h8, 16'h0108, 32'h4000_0100, 4'b0000);
    send(4'h9, 16'h010c, 32'hc000_0103, 4'b0010);
    wait_idle();
    chk(sticky_err == 1'b0, "R7", "no sticky from forwarded errors", 64'(sticky_err), 64'd0);

    // reserved encodings, including one with the bufferable bit set (R1)
    send(4'ha, 16'h0200, 32'h8000_0200, 4'b0101);
    send(4'hb, 16'h0204, 32'h0000_0201, 4'b1001);
    send(4'hc, 16'h0208, 32'h0000_0202, 4'b1100);
    wait_idle();

    // fill the queue, then a same-ID strict write behind it (R6, R5)
    dn_gate = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      send(4'h5, 16'(16'h0300 + 4 * i), 32'(32'h0000_0300 + i), 4'b0001);
    @(negedge clk); #3;
    chk(up_ready == 1'b0, "R6", "up_ready with full queue", 64'(up_ready), 64'd0);
    chk(dn_valid == 1'b1, "R6", "dn_valid with held writes", 64'(dn_valid), 64'd1);
    fork
      send(4'h5, 16'h0310, 32'h4000_0310, 4'b0000);
      begin repeat (5) @(negedge clk); dn_gate = 1'b1; end
    join
    wait_idle();

    // absorbed slave error on a bufferable write (R7)
    send(4'hd, 16'h0400, 32'h8000_0401, 4'b0011);
    wait_idle();
    chk(exp_sticky == 1'b1, "R7", "model saw absorbed error", 64'(exp_sticky), 64'd1);
    chk(sticky_err == 1'b1, "R7", "sticky_err after absorbed error", 64'(sticky_err), 64'd1);
    send(4'he, 16'h0404, 32'h0000_0400, 4'b0001);
    wait_idle();
    chk(sticky_err == 1'b1, "R7", "sticky_err holds", 64'(sticky_err), 64'd1);

    // master stalls its response (R10)
    timed = 1'b0;
    up_rsp_ready = 1'b0;
    send(4'hf, 16'h0500, 32'h0000_0500, 4'b0001);
    repeat (3) @(negedge clk);
    #3;
    chk(up_rsp_valid == 1'b1 && up_rsp_id == 4'hf, "R10", "held response",
        64'({up_rsp_valid, up_rsp_id}), 64'h1f);
    chk(up_ready == 1'b0, "R10", "intake closed by busy slot", 64'(up_ready), 64'd0);
    @(negedge clk);
    up_rsp_ready = 1'b1;
    wait_idle();
    timed = 1'b1;

    // reset with writes still held (R9)
    dn_gate = 1'b0;
    send(4'h2, 16'h0600, 32'h0000_0600, 4'b0001);
    send(4'h3, 16'h0604, 32'h0000_0601, 4'b0001);
    repeat (2) @(negedge clk);
    do_reset();
    chk(dn_valid == 1'b0, "R9", "dn_valid after mid-run reset", 64'(dn_valid), 64'd0);
    chk(sticky_err == 1'b0, "R9", "sticky cleared by reset", 64'(sticky_err), 64'd0);
    dn_gate = 1'b1;
    repeat (6) @(negedge clk);
    #3;
    chk(dn_valid == 1'b0, "R9", "queue emptied by reset", 64'(dn_valid), 64'd0);
    chk(up_ready == 1'b1, "R9", "up_ready after mid-run reset", 64'(up_ready), 64'd1);

    // traffic after reset still ordered (R4)
    send(4'h1, 16'h0700, 32'h0000_0700, 4'b0001);
    send(4'h2, 16'h0704, 32'h0000_0701, 4'b0000);
    wait_idle();

    chk(dn_exp.size() == 0, "R4", "all downstream writes seen", 64'(dn_exp.size()), 64'd0);
    chk(rsp_exp.size() == 0, "R3", "all responses seen", 64'(rsp_exp.size()), 64'd0);
    chk(r8_viol == 0, "R8", "single outstanding downstream", 64'(r8_viol), 64'd0);
    finish_run();
  end
endmodule